// File: doc/BRIEF.md
# Triggered Pattern Next-Data Buffer

This block is a double-buffered output stage for an 8-bit timing pattern that is split into two 4-bit output groups. Software places the next pattern in a buffer register over a simple register bus. When the timer compare-match pulse chosen for a group arrives, that group's buffered nibble is copied into the live output register. The output can therefore change at a precise timer instant, while software prepares the following value at its own pace.

Each group picks one of four compare-match pulse inputs. When both groups pick the same pulse, the two groups count as sharing a trigger. In that case the whole buffer sits in one bus byte. When the groups pick different pulses, the buffer is split across two bus bytes. Reset and two low-power modes arrive as input signals. Hardware standby clears both registers. Software standby freezes both registers.

Top module: `pattern_buffer`

## Requirements
- R1: Reset (`rstN` low) and hardware standby (`hwStandby` high) clear both the buffer and `patOut` to 0x00. Hardware standby takes priority over every other input.
- R2: With a shared trigger (`trigSel1 == trigSel0`), a write at offset 0xFFFA5 stores all 8 data bits. A read there returns the full buffer.
- R3: With a shared trigger, offset 0xFFFA7 reads 0xFF and ignores writes.
- R4: With separate triggers, a write at 0xFFFA5 updates only buffer bits 7..4 (group 1). A read there returns {bits 7..4, 4'hF}.
- R5: With separate triggers, a write at 0xFFFA7 updates only buffer bits 3..0 (group 0). A read there returns {4'hF, bits 3..0}.
- R6: On a rising clock edge where `cmpMatch[trigSelN]` is high and group N is enabled, group N's buffered nibble appears on its bits of `patOut` (group 1 on 7..4, group 0 on 3..0) right after that edge.
- R7: Output bits of a group whose `grpEnable` bit is 0 keep their value when a trigger arrives (bit 1 is group 1, bit 0 is group 0).
- R8: A compare-match pulse updates only the groups that select it. A group whose selected pulse stays low keeps its output.
- R9: When a bus write and a trigger hit the same group in the same cycle, the output receives the previously buffered value. The written value is kept for the next trigger.
- R10: While `swStandby` is high, bus writes and triggers are ignored and both registers hold their values.
- R11: Reads at any other offset return 0x00, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hwStandby | input | 1 | Hardware standby: clears the registers |
| swStandby | input | 1 | Software standby: freezes the registers |
| busAddr | input | 20 | Register bus byte offset |
| busWe | input | 1 | Register bus write enable |
| busWdata | input | 8 | Register bus write data |
| busRdata | output | 8 | Register bus read data (combinational from address) |
| trigSel1 | input | 2 | Compare-match pulse selected by group 1 |
| trigSel0 | input | 2 | Compare-match pulse selected by group 0 |
| cmpMatch | input | 4 | Timer compare-match pulses |
| grpEnable | input | 2 | Pattern output enable per group |
| patOut | output | 8 | Live pattern output register |

## Verification
The transfer is exercised in three ways: with one pulse that both groups share, with distinct pulses fired one at a time, and with pulses that hit both groups while only one group is enabled. Comparing these cases separates a correct per-group pulse selection from an OR of all pulses, and separates a working enable mask from a missing one. Bus access is tried at both mapped offsets under both trigger settings, which shows whether the address layout really switches with the setting and whether reserved nibbles read as ones. A write that coincides with a trigger shows that the output takes the old buffered value. Standby pulses show the difference between clearing and freezing.

// File: rtl/pattern_buffer_pkg.sv
package pattern_buffer_pkg;
  localparam int GRP_COUNT = 2;
  localparam int GRP_BITS  = 4;
  localparam int DATA_BITS = GRP_COUNT * GRP_BITS;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_FULL,
    RD_UPPER,
    RD_LOWER,
    RD_ONES
  } rdSel_t;

  typedef struct packed {
    logic                 clear;
    logic                 hold;
    logic [GRP_COUNT-1:0] wrGrp;
    logic [GRP_COUNT-1:0] xferGrp;
    rdSel_t               rdSel;
  } strobes_t;
endpackage

// File: rtl/pattern_buffer_ctrl.sv
module pattern_buffer_ctrl
  import pattern_buffer_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter logic [ADDR_W-1:0] ADDR_A = 20'hFFFA5,
  parameter logic [ADDR_W-1:0] ADDR_B = 20'hFFFA7,
  parameter int NUM_TRIG = 4,
  localparam int SEL_W   = $clog2(NUM_TRIG)
) (
  input  logic                            hwStandby,
  input  logic                            swStandby,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic                            busWe,
  input  logic [GRP_COUNT-1:0][SEL_W-1:0] trigSel,
  input  logic [NUM_TRIG-1:0]             cmpMatch,
  input  logic [GRP_COUNT-1:0]            grpEnable,
  output strobes_t                        strobes
);
  logic hitA;
  logic hitB;
  logic sharedTrig;
  logic [GRP_COUNT-1:0] trigHit;

  assign hitA = (busAddr == ADDR_A);
  assign hitB = (busAddr == ADDR_B);

  // The groups share a trigger when every selector matches group 0's.
  always_comb begin
    sharedTrig = 1'b1;
    for (int g = 1; g < GRP_COUNT; g++) begin
      if (trigSel[g] != trigSel[0]) sharedTrig = 1'b0;
    end
  end

  for (genvar g = 0; g < GRP_COUNT; g++) begin : gTrig
    assign trigHit[g] = cmpMatch[trigSel[g]] & grpEnable[g];
  end

  always_comb begin
    strobes.clear   = hwStandby;
    strobes.hold    = swStandby;
    strobes.wrGrp   = '0;
    strobes.xferGrp = '0;
    strobes.rdSel   = RD_NONE;
    if (sharedTrig) begin
      if (hitA) strobes.rdSel = RD_FULL;
      else if (hitB) strobes.rdSel = RD_ONES;
      if (busWe && hitA) strobes.wrGrp = '1;
    end else begin
      if (hitA) strobes.rdSel = RD_UPPER;
      else if (hitB) strobes.rdSel = RD_LOWER;
      if (busWe && hitA) strobes.wrGrp[1] = 1'b1;
      if (busWe && hitB) strobes.wrGrp[0] = 1'b1;
    end
    if (!hwStandby && !swStandby) strobes.xferGrp = trigHit;
    if (hwStandby || swStandby) strobes.wrGrp = '0;
  end
endmodule

// File: rtl/pattern_buffer_dp.sv
module pattern_buffer_dp
  import pattern_buffer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strobes,
  input  logic [DATA_BITS-1:0] busWdata,
  output logic [DATA_BITS-1:0] nextData,
  output logic [DATA_BITS-1:0] outData,
  output logic [DATA_BITS-1:0] readData
);
  for (genvar g = 0; g < GRP_COUNT; g++) begin : gGroup
    logic [GRP_BITS-1:0] nextNib;
    logic [GRP_BITS-1:0] outNib;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        nextNib <= '0;
        outNib  <= '0;
      end else if (strobes.clear) begin
        nextNib <= '0;
        outNib  <= '0;
      end else if (!strobes.hold) begin
        if (strobes.wrGrp[g])   nextNib <= busWdata[g*GRP_BITS +: GRP_BITS];
        if (strobes.xferGrp[g]) outNib  <= nextNib;
      end
    end

    assign nextData[g*GRP_BITS +: GRP_BITS] = nextNib;
    assign outData[g*GRP_BITS +: GRP_BITS]  = outNib;
  end

  localparam int HALF = DATA_BITS / 2;

  always_comb begin
    unique case (strobes.rdSel)
      RD_FULL:  readData = nextData;
      RD_UPPER: readData = {nextData[DATA_BITS-1 -: HALF], {HALF{1'b1}}};
      RD_LOWER: readData = {{HALF{1'b1}}, nextData[HALF-1:0]};
      RD_ONES:  readData = '1;
      default:  readData = '0;
    endcase
  end
endmodule

// File: rtl/pattern_buffer.sv
module pattern_buffer
  import pattern_buffer_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter logic [ADDR_W-1:0] ADDR_A = 20'hFFFA5,
  parameter logic [ADDR_W-1:0] ADDR_B = 20'hFFFA7,
  parameter int NUM_TRIG = 4,
  localparam int SEL_W   = $clog2(NUM_TRIG)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hwStandby,
  input  logic                 swStandby,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [DATA_BITS-1:0] busWdata,
  output logic [DATA_BITS-1:0] busRdata,
  input  logic [SEL_W-1:0]     trigSel1,
  input  logic [SEL_W-1:0]     trigSel0,
  input  logic [NUM_TRIG-1:0]  cmpMatch,
  input  logic [GRP_COUNT-1:0] grpEnable,
  output logic [DATA_BITS-1:0] patOut
);
  strobes_t strobes;
  logic [GRP_COUNT-1:0][SEL_W-1:0] trigSel;
  logic [DATA_BITS-1:0] nextData;

  assign trigSel = {trigSel1, trigSel0};

  pattern_buffer_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B), .NUM_TRIG(NUM_TRIG)
  ) u_ctrl (
    .hwStandby(hwStandby), .swStandby(swStandby), .busAddr(busAddr),
    .busWe(busWe), .trigSel(trigSel), .cmpMatch(cmpMatch),
    .grpEnable(grpEnable), .strobes(strobes)
  );

  pattern_buffer_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata),
    .nextData(nextData), .outData(patOut), .readData(busRdata)
  );
endmodule

// File: rtl/pattern_buffer_chk.sv
module pattern_buffer_chk #(
  parameter int ADDR_W   = 20,
  parameter logic [ADDR_W-1:0] ADDR_A = 20'hFFFA5,
  parameter logic [ADDR_W-1:0] ADDR_B = 20'hFFFA7,
  parameter int NUM_TRIG = 4,
  localparam int SEL_W   = $clog2(NUM_TRIG)
) (
  input logic                clk,
  input logic                rstN,
  input logic                hwStandby,
  input logic                swStandby,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [7:0]          busRdata,
  input logic [SEL_W-1:0]    trigSel1,
  input logic [SEL_W-1:0]    trigSel0,
  input logic [NUM_TRIG-1:0] cmpMatch,
  input logic [1:0]          grpEnable,
  input logic [7:0]          patOut,
  input logic [7:0]          nextData
);
  AST_HWSTBY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    hwStandby |=> (patOut == 8'h00 && nextData == 8'h00)); // R1

  AST_SHARED_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    (trigSel1 == trigSel0 && busAddr == ADDR_B) |-> busRdata == 8'hFF); // R3

  AST_UPPER_XFER: assert property (@(posedge clk) disable iff (!rstN)
    (!hwStandby && !swStandby && grpEnable[1] && cmpMatch[trigSel1])
      |=> patOut[7:4] == $past(nextData[7:4])); // R6

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!hwStandby && !grpEnable[0]) |=> patOut[3:0] == $past(patOut[3:0])); // R7

  AST_SWSTBY_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (swStandby && !hwStandby) |=> ($stable(patOut) && $stable(nextData))); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != ADDR_A && busAddr != ADDR_B) |-> busRdata == 8'h00); // R11
endmodule

bind pattern_buffer pattern_buffer_chk #(
  .ADDR_W(ADDR_W), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B), .NUM_TRIG(NUM_TRIG)
) u_chk (
  .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .swStandby(swStandby),
  .busAddr(busAddr), .busRdata(busRdata), .trigSel1(trigSel1),
  .trigSel0(trigSel0), .cmpMatch(cmpMatch), .grpEnable(grpEnable),
  .patOut(patOut), .nextData(nextData)
);

// File: tb/pattern_buffer_bench.sv
module pattern_buffer_bench;
  localparam logic [19:0] OFF_A  = 20'hFFFA5;
  localparam logic [19:0] OFF_B  = 20'hFFFA7;
  localparam logic [19:0] OFF_NA = 20'h00100;
  localparam int NVEC = 16;

  // {tag[40:37], addrCode[36:35], we[34], wdata[33:26], sel1[25:24],
  //  sel0[23:22], en[21:20], cmp[19:16], expOut[15:8], expRd[7:0]}
  localparam logic [40:0] VEC [NVEC] = '{
    {4'd2,  2'd0, 1'b1, 8'h3C, 2'd0, 2'd0, 2'b11, 4'h0, 8'h00, 8'h3C}, // R2
    {4'd6,  2'd0, 1'b0, 8'h00, 2'd0, 2'd0, 2'b11, 4'h1, 8'h3C, 8'h3C}, // R6
    {4'd3,  2'd1, 1'b1, 8'h55, 2'd0, 2'd0, 2'b11, 4'h0, 8'h3C, 8'hFF}, // R3
    {4'd3,  2'd0, 1'b0, 8'h00, 2'd0, 2'd0, 2'b11, 4'h0, 8'h3C, 8'h3C}, // R3
    {4'd4,  2'd0, 1'b1, 8'hA7, 2'd1, 2'd2, 2'b11, 4'h0, 8'h3C, 8'hAF}, // R4
    {4'd5,  2'd1, 1'b1, 8'h51, 2'd1, 2'd2, 2'b11, 4'h0, 8'h3C, 8'hF1}, // R5
    {4'd8,  2'd1, 1'b0, 8'h00, 2'd1, 2'd2, 2'b11, 4'h2, 8'hAC, 8'hF1}, // R8
    {4'd8,  2'd1, 1'b0, 8'h00, 2'd1, 2'd2, 2'b11, 4'h4, 8'hA1, 8'hF1}, // R8
    {4'd11, 2'd2, 1'b1, 8'h99, 2'd1, 2'd2, 2'b11, 4'h0, 8'hA1, 8'h00}, // R11
    {4'd11, 2'd0, 1'b0, 8'h00, 2'd1, 2'd2, 2'b11, 4'h0, 8'hA1, 8'hAF}, // R11
    {4'd4,  2'd0, 1'b1, 8'h5F, 2'd1, 2'd2, 2'b11, 4'h0, 8'hA1, 8'h5F}, // R4
    {4'd5,  2'd1, 1'b1, 8'h06, 2'd1, 2'd2, 2'b11, 4'h0, 8'hA1, 8'hF6}, // R5
    {4'd7,  2'd1, 1'b0, 8'h00, 2'd1, 2'd2, 2'b01, 4'h6, 8'hA6, 8'hF6}, // R7
    {4'd7,  2'd1, 1'b0, 8'h00, 2'd1, 2'd2, 2'b10, 4'h6, 8'h56, 8'hF6}, // R7
    {4'd9,  2'd0, 1'b1, 8'h90, 2'd1, 2'd2, 2'b11, 4'h2, 8'h56, 8'h9F}, // R9
    {4'd9,  2'd0, 1'b0, 8'h00, 2'd1, 2'd2, 2'b11, 4'h2, 8'h96, 8'h9F}  // R9
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hwStandby = 1'b0;
  logic swStandby = 1'b0;
  logic [19:0] busAddr = OFF_A;
  logic busWe = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic [1:0] trigSel1 = 2'd0;
  logic [1:0] trigSel0 = 2'd0;
  logic [3:0] cmpMatch = 4'h0;
  logic [1:0] grpEnable = 2'b11;
  logic [7:0] patOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pattern_buffer u_pattern_buffer (
    .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .swStandby(swStandby),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .trigSel1(trigSel1), .trigSel0(trigSel0), .cmpMatch(cmpMatch),
    .grpEnable(grpEnable), .patOut(patOut)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] addrOf(input logic [1:0] code);
    case (code)
      2'd0:    return OFF_A;
      2'd1:    return OFF_B;
      default: return OFF_NA;
    endcase
  endfunction

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1", "patOut in reset", patOut, 8'h00);
    check("R1", "readback in reset", busRdata, 8'h00);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      busAddr   = addrOf(VEC[i][36:35]);
      busWe     = VEC[i][34];
      busWdata  = VEC[i][33:26];
      trigSel1  = VEC[i][25:24];
      trigSel0  = VEC[i][23:22];
      grpEnable = VEC[i][21:20];
      cmpMatch  = VEC[i][19:16];
      @(posedge clk);
      #2;
      busWe = 1'b0;
      cmpMatch = 4'h0;
      check($sformatf("R%0d", VEC[i][40:37]), $sformatf("vec %0d patOut", i),
            patOut, VEC[i][15:8]);
      check($sformatf("R%0d", VEC[i][40:37]), $sformatf("vec %0d readback", i),
            busRdata, VEC[i][7:0]);
    end

    // R10: software standby freezes both registers
    @(negedge clk);
    swStandby = 1'b1;
    busAddr = OFF_A; busWe = 1'b1; busWdata = 8'h11; cmpMatch = 4'hF;
    @(posedge clk); #2;
    busWe = 1'b0; cmpMatch = 4'h0;
    check("R10", "patOut in sw standby", patOut, 8'h96);
    check("R10", "buffer in sw standby", busRdata, 8'h9F);

    // R1: hardware standby clears, and wins over software standby
    @(negedge clk);
    hwStandby = 1'b1;
    @(posedge clk); #2;
    check("R1", "patOut after hw standby", patOut, 8'h00);
    check("R1", "buffer after hw standby", busRdata, 8'h0F);
    @(negedge clk);
    hwStandby = 1'b0; swStandby = 1'b0;

    // R6: shared trigger on pulse 3
    trigSel1 = 2'd3; trigSel0 = 2'd3;
    busWe = 1'b1; busWdata = 8'hE4;
    @(posedge clk); #2;
    busWe = 1'b0;
    @(negedge clk);
    cmpMatch = 4'h8;
    @(posedge clk); #2;
    cmpMatch = 4'h0;
    check("R6", "patOut after pulse 3", patOut, 8'hE4);

    // R1: asynchronous reset
    @(negedge clk);
    rstN = 1'b0;
    #2;
    check("R1", "patOut on async reset", patOut, 8'h00);
    check("R1", "buffer on async reset", busRdata, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    finish();
  end
endmodule